// File: doc/BRIEF.md
# Column-fed 3x3 image convolver with cascade path

The block computes a weighted 3x3 neighbourhood sum over a stream of image columns. On every clock it takes one column of three signed 12-bit pixels, one per image row, and pushes it into a window of three shift rows, each three columns deep. The window therefore moves across the image by one column per clock. Each of the nine window positions is weighted by a stored 10-bit signed fractional coefficient. The nine products are added together with a 16-bit cascade word, and the result is rounded to a 16-bit cascade output. Two or more blocks can be chained through the cascade ports to build larger kernels. Line buffering, which supplies the vertically adjacent pixels, sits outside the block.

Coefficients are loaded three at a time. A 2-bit set code chooses which window column the three coefficient ports write, and the code zero holds every coefficient. The stream runs freely with no handshake and no back-pressure. A column is accepted on every clock edge and a result leaves on every clock edge. A neighbour block or a line store upstream must therefore supply a valid column on every cycle, or pass zero columns that are then discarded downstream.

Top module: `conv3x3_cascade`

## Requirements
- R1: While reset is asserted, the cascade output and all nine coefficients are zero. The output stays zero after the first three clock edges that follow the release of reset.
- R2: The column captured at edge n is the newest window column. The column from edge n-1 is the middle column and the column from edge n-2 is the oldest. After edge n+4 the output is the sum of three terms. The first is each row's newest pixel times that row's set-3 coefficient. The second is each middle pixel times the set-2 coefficient. The third is each oldest pixel times the set-1 coefficient. The cascade input from edge n+1 is added, and the sum is rounded.
- R3: The window slides by exactly one column per clock, and one result is produced per clock, with a fixed 4-edge latency from column to output.
- R4: The cascade input reaches the output through exactly 4 registers. With an all-zero window, the output equals the cascade input from 4 edges earlier.
- R5: Pixels are two's complement integers. A coefficient code k has the value k/512 (10 bits, 9 fraction bits). Cascade words are two's complement with 4 fraction bits (12.4).
- R6: The exact sum is rounded to 1/16 by adding 1/32 and then truncating toward minus infinity, so ties round upward.
- R7: No saturation is applied. The output is the rounded value modulo 2^16.
- R8: Set code 1, 2 or 3 on `ksel` writes `kval_a`, `kval_b` and `kval_c` into the row A, B and C coefficients of that set at the clock edge. The output for the column captured at edge n uses the coefficients as they stand after edge n.
- R9: Set code 0 leaves all nine coefficients unchanged, whatever is on the coefficient ports.
- R10: Suppose one column holds the value P on all three rows and the columns around it are zero. The output then shows P times the sum of the set-3 coefficients, then P times the set-2 sum, then P times the set-1 sum, on three consecutive cycles starting 4 edges after the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_a | input | 12 | Row A pixel of the incoming column |
| pix_b | input | 12 | Row B pixel of the incoming column |
| pix_c | input | 12 | Row C pixel of the incoming column |
| ksel | input | 2 | Coefficient set code: 0 hold, 1..3 write that set |
| kval_a | input | 10 | Row A coefficient for the selected set |
| kval_b | input | 10 | Row B coefficient for the selected set |
| kval_c | input | 10 | Row C coefficient for the selected set |
| cas_in | input | 16 | Cascade input word, 12.4 format |
| cas_out | output | 16 | Rounded cascade output word, 12.4 format |

## Verification
A column driven before edge n is due at the output after edge n+4. The cascade word that goes with it is the one sampled at edge n+1. The coefficients that apply are the ones standing after edge n. The bench numbers every edge after reset and keeps the last eight columns, cascade words and coefficient snapshots in circular history. After each edge it rebuilds the value due from the entries at n, n-1, n-2 and n+1, and compares it with the output half a period after that edge. This catches an extra or missing register on either path, and a coefficient write that lands one cycle early or late.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  // Set code that leaves the coefficient bank untouched.
  localparam int KSEL_HOLD = 0;

  // Code that addresses coefficient set index s (0-based, oldest column first).
  function automatic int set_code(input int s);
    return s + 1;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/conv3_window.sv
module conv3_window #(
  parameter int PIX_W = 12,
  parameter int ROWS  = 3,
  parameter int TAPS  = 3,
  localparam int COL_W = ROWS * PIX_W,
  localparam int WIN_W = ROWS * TAPS * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] col_in,
  output logic [WIN_W-1:0] win
);
  // tap 0 holds the newest column, tap TAPS-1 the oldest
  logic [PIX_W-1:0] tap_q [ROWS][TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int t = 0; t < TAPS; t++)
          tap_q[r][t] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        tap_q[r][0] <= col_in[r*PIX_W +: PIX_W];
        for (int t = 1; t < TAPS; t++)
          tap_q[r][t] <= tap_q[r][t-1];
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign win[(r*TAPS+t)*PIX_W +: PIX_W] = tap_q[r][t];
    end
  end
endmodule

// File: rtl/conv3_coef_bank.sv
module conv3_coef_bank
  import conv3_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int ROWS   = 3,
  parameter int TAPS   = 3,
  localparam int SEL_W  = $clog2(TAPS + 1),
  localparam int KIN_W  = ROWS * COEF_W,
  localparam int BANK_W = ROWS * TAPS * COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  ksel,
  input  logic [KIN_W-1:0]  kval,
  output logic [BANK_W-1:0] kset
);
  // set index s is written by code s+1; code KSEL_HOLD writes nothing
  logic [COEF_W-1:0] k_q [ROWS][TAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int s = 0; s < TAPS; s++)
          k_q[r][s] <= '0;
    end else if (ksel != SEL_W'(KSEL_HOLD)) begin
      for (int s = 0; s < TAPS; s++)
        if (ksel == SEL_W'(set_code(s)))
          for (int r = 0; r < ROWS; r++)
            k_q[r][s] <= kval[r*COEF_W +: COEF_W];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar s = 0; s < TAPS; s++) begin : g_set
      assign kset[(r*TAPS+s)*COEF_W +: COEF_W] = k_q[r][s];
    end
  end
endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
  import conv3_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int COEF_W   = 10,
  parameter int CAS_W    = 16,
  parameter int CAS_FRAC = 4,
  parameter int ROWS     = 3,
  parameter int TAPS     = 3,
  localparam int WIN_W  = ROWS * TAPS * PIX_W,
  localparam int BANK_W = ROWS * TAPS * COEF_W,
  localparam int NPROD  = ROWS * TAPS,
  localparam int PROD_W = PIX_W + COEF_W,
  localparam int ROW_W  = PROD_W + $clog2(TAPS + 1),
  localparam int SUM_W  = ROW_W + $clog2(ROWS + 1),
  localparam int SHIFT  = COEF_W - 1 - CAS_FRAC,
  localparam int ACC_W  = max_int(SUM_W, CAS_W + SHIFT) + 1,
  localparam int HALF   = 1 << (SHIFT - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  win,
  input  logic [BANK_W-1:0] kset,
  input  logic [CAS_W-1:0]  cas_in,
  output logic [CAS_W-1:0]  cas_out
);
  logic signed [PROD_W-1:0] prod_d [NPROD];
  logic signed [PROD_W-1:0] prod_q [NPROD];
  logic signed [ROW_W-1:0]  row_d  [ROWS];
  logic signed [ROW_W-1:0]  row_q  [ROWS];
  logic signed [CAS_W-1:0]  cas1_q, cas2_q;
  logic signed [ACC_W-1:0]  acc_d, acc_q, rnd;

  // newest window tap meets the highest coefficient set
  always_comb begin
    for (int r = 0; r < ROWS; r++)
      for (int t = 0; t < TAPS; t++)
        prod_d[r*TAPS+t] =
          PROD_W'($signed(win[(r*TAPS+t)*PIX_W +: PIX_W])) *
          PROD_W'($signed(kset[(r*TAPS+(TAPS-1-t))*COEF_W +: COEF_W]));
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_d[r] = '0;
      for (int t = 0; t < TAPS; t++)
        row_d[r] = row_d[r] + ROW_W'(prod_q[r*TAPS+t]);
    end
  end

  // cascade word aligned to the product scale
  always_comb begin
    acc_d = ACC_W'(cas2_q) <<< SHIFT;
    for (int r = 0; r < ROWS; r++)
      acc_d = acc_d + ACC_W'(row_q[r]);
  end

  assign rnd = acc_q + ACC_W'(HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPROD; i++) prod_q[i] <= '0;
      for (int r = 0; r < ROWS; r++)  row_q[r]  <= '0;
      cas1_q  <= '0;
      cas2_q  <= '0;
      acc_q   <= '0;
      cas_out <= '0;
    end else begin
      for (int i = 0; i < NPROD; i++) prod_q[i] <= prod_d[i];
      for (int r = 0; r < ROWS; r++)  row_q[r]  <= row_d[r];
      cas1_q  <= cas_in;
      cas2_q  <= cas1_q;
      acc_q   <= acc_d;
      cas_out <= CAS_W'(rnd >>> SHIFT);
    end
  end
endmodule

// File: rtl/conv3x3_cascade.sv
module conv3x3_cascade
  import conv3_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int COEF_W   = 10,
  parameter int CAS_W    = 16,
  parameter int CAS_FRAC = 4,
  parameter int TAPS     = 3,
  localparam int SEL_W = $clog2(TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_a,
  input  logic [PIX_W-1:0]  pix_b,
  input  logic [PIX_W-1:0]  pix_c,
  input  logic [SEL_W-1:0]  ksel,
  input  logic [COEF_W-1:0] kval_a,
  input  logic [COEF_W-1:0] kval_b,
  input  logic [COEF_W-1:0] kval_c,
  input  logic [CAS_W-1:0]  cas_in,
  output logic [CAS_W-1:0]  cas_out
);
  localparam int ROWS   = 3;
  localparam int WIN_W  = ROWS * TAPS * PIX_W;
  localparam int BANK_W = ROWS * TAPS * COEF_W;

  logic [WIN_W-1:0]  win_w;
  logic [BANK_W-1:0] kset_w;

  conv3_window #(.PIX_W(PIX_W), .ROWS(ROWS), .TAPS(TAPS)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .col_in ({pix_c, pix_b, pix_a}),
    .win    (win_w)
  );

  conv3_coef_bank #(.COEF_W(COEF_W), .ROWS(ROWS), .TAPS(TAPS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .ksel  (ksel),
    .kval  ({kval_c, kval_b, kval_a}),
    .kset  (kset_w)
  );

  conv3_mac #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .CAS_W(CAS_W),
    .CAS_FRAC(CAS_FRAC), .ROWS(ROWS), .TAPS(TAPS)
  ) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .win     (win_w),
    .kset    (kset_w),
    .cas_in  (cas_in),
    .cas_out (cas_out)
  );
endmodule

// File: rtl/conv3x3_cascade_chk.sv
module conv3x3_cascade_chk #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 10,
  parameter int CAS_W  = 16,
  parameter int TAPS   = 3,
  localparam int ROWS   = 3,
  localparam int SEL_W  = $clog2(TAPS + 1),
  localparam int BANK_W = ROWS * TAPS * COEF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PIX_W-1:0]  pix_a,
  input logic [PIX_W-1:0]  pix_b,
  input logic [PIX_W-1:0]  pix_c,
  input logic [SEL_W-1:0]  ksel,
  input logic [COEF_W-1:0] kval_a,
  input logic [COEF_W-1:0] kval_b,
  input logic [COEF_W-1:0] kval_c,
  input logic [BANK_W-1:0] kset,
  input logic [CAS_W-1:0]  cas_in,
  input logic [CAS_W-1:0]  cas_out
);
  logic [3:0] since_q;
  logic       zcol;
  logic [ROWS*COEF_W-1:0] kin;

  assign zcol = (pix_a == '0) && (pix_b == '0) && (pix_c == '0);
  assign kin  = {kval_c, kval_b, kval_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 4'hF) since_q <= since_q + 4'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < 4'd4) |-> (cas_out == '0)); // R1

  AST_CASCADE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_q >= 4'd8) && $past(zcol, 5) && $past(zcol, 6) && $past(zcol, 7))
      |-> (cas_out == $past(cas_in, 4))); // R4

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ksel == '0) |=> $stable(kset)); // R9

  for (genvar s = 0; s < TAPS; s++) begin : g_set
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      AST_WRITE_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        (ksel == SEL_W'(s + 1)) |=>
          (kset[(r*TAPS+s)*COEF_W +: COEF_W] == $past(kin[r*COEF_W +: COEF_W]))); // R8
    end
  end
endmodule

bind conv3x3_cascade conv3x3_cascade_chk #(
  .PIX_W(PIX_W), .COEF_W(COEF_W), .CAS_W(CAS_W), .TAPS(TAPS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pix_a   (pix_a),
  .pix_b   (pix_b),
  .pix_c   (pix_c),
  .ksel    (ksel),
  .kval_a  (kval_a),
  .kval_b  (kval_b),
  .kval_c  (kval_c),
  .kset    (kset_w),
  .cas_in  (cas_in),
  .cas_out (cas_out)
);

// File: tb/conv3x3_cascade_bench.sv
module conv3x3_cascade_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [11:0] pix_a, pix_b, pix_c;
  logic [1:0]  ksel;
  logic [9:0]  kval_a, kval_b, kval_c;
  logic [15:0] cas_in;
  logic [15:0] cas_out;

  conv3x3_cascade u_conv3x3_cascade (
    .clk(clk), .rst_n(rst_n),
    .pix_a(pix_a), .pix_b(pix_b), .pix_c(pix_c),
    .ksel(ksel), .kval_a(kval_a), .kval_b(kval_b), .kval_c(kval_c),
    .cas_in(cas_in), .cas_out(cas_out)
  );

  int checks = 0;
  int fails  = 0;
  int edge_n = 0;
  int ph [8][3];
  int cs [8];
  int kh [8][3][3];
  int kcur [3][3];

  // value due after edge e: column n = e-4, cascade word of n+1 (R2, R4, R6, R7)
  function automatic logic [15:0] model(input int e);
    longint acc = 0;
    int n = e - 4;
    for (int t = 0; t < 3; t++) begin
      int m = n - t;
      if (m >= 1)
        for (int r = 0; r < 3; r++)
          acc += longint'(ph[m % 8][r]) * longint'(kh[n % 8][r][2 - t]);
    end
    if (n + 1 >= 1) acc += longint'(cs[(n + 1) % 8]) * 32;
    acc += 16;
    acc = acc >>> 5;
    return acc[15:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (cas_out !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: cas_out=%h expected %h", tag, edge_n, cas_out, exp);
    end
  endtask

  task automatic step(input logic [11:0] a, b, c, input logic [9:0] ka, kb, kc,
                      input logic [1:0] sel, input logic [15:0] cin, input string tag);
    int idx;
    pix_a = a; pix_b = b; pix_c = c;
    kval_a = ka; kval_b = kb; kval_c = kc;
    ksel = sel; cas_in = cin;
    edge_n++;
    idx = edge_n % 8;
    ph[idx][0] = int'($signed(a));
    ph[idx][1] = int'($signed(b));
    ph[idx][2] = int'($signed(c));
    cs[idx] = int'($signed(cin));
    if (sel != 2'd0) begin
      kcur[0][sel - 1] = int'($signed(ka));
      kcur[1][sel - 1] = int'($signed(kb));
      kcur[2][sel - 1] = int'($signed(kc));
    end
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 3; s++)
        kh[idx][r][s] = kcur[r][s];
    @(posedge clk);
    @(negedge clk);
    check(tag, model(edge_n));
  endtask

  function automatic logic [11:0] rpix();
    return 12'($urandom);
  endfunction
  function automatic logic [9:0] rk();
    return 10'($urandom);
  endfunction
  function automatic logic [15:0] rc();
    return 16'($urandom);
  endfunction
  function automatic logic [11:0] xpix();
    case ($urandom % 6)
      0: return 12'h800;
      1: return 12'h7FF;
      2: return 12'h000;
      3: return 12'h001;
      4: return 12'hFFF;
      default: return rpix();
    endcase
  endfunction
  function automatic logic [9:0] xk();
    case ($urandom % 5)
      0: return 10'h200;
      1: return 10'h1FF;
      2: return 10'h3FF;
      3: return 10'h001;
      default: return rk();
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run still busy, actual hung, expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 3; s++)
        kcur[r][s] = 0;
    rst_n = 1'b0;
    pix_a = 12'h123; pix_b = 12'h456; pix_c = 12'h789;
    kval_a = 10'h155; kval_b = 10'h0AA; kval_c = 10'h3C3;
    ksel = 2'd3; cas_in = 16'hBEEF;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);                       // R1: output zero in reset
    rst_n = 1'b1;

    // R1: coefficients cleared by reset, so only the cascade word shows up at edge 4
    for (int i = 0; i < 6; i++) step(rpix(), rpix(), rpix(), rk(), rk(), rk(), 2'd0, rc(), "R1");

    // R8: load three sets, then R10: impulse column gives set-3, set-2, set-1 sums
    step(12'd0, 12'd0, 12'd0, 10'd64,  10'h3E0, 10'd16,  2'd1, 16'd0, "R8");
    step(12'd0, 12'd0, 12'd0, 10'd128, 10'd8,   10'h3F8, 2'd2, 16'd0, "R8");
    step(12'd0, 12'd0, 12'd0, 10'h300, 10'd100, 10'd3,   2'd3, 16'd0, "R8");
    for (int i = 0; i < 3; i++) step(12'd0, 12'd0, 12'd0, rk(), rk(), rk(), 2'd0, 16'd0, "R10");
    step(12'd100, 12'd100, 12'd100, rk(), rk(), rk(), 2'd0, 16'd0, "R10");
    for (int i = 0; i < 8; i++) step(12'd0, 12'd0, 12'd0, rk(), rk(), rk(), 2'd0, 16'd0, "R10");

    // R4: zero window, cascade word passes through 4 registers
    for (int i = 0; i < 16; i++) step(12'd0, 12'd0, 12'd0, rk(), rk(), rk(), 2'd0, rc(), "R4");

    // R6: coefficient 16/512 makes pixel/32 terms, i.e. ties at half an output LSB
    for (int s = 1; s <= 3; s++)
      step(12'd0, 12'd0, 12'd0, 10'd16, 10'd16, 10'd16, 2'(s), 16'd0, "R6");
    for (int i = 0; i < 24; i++) begin
      logic [11:0] p;
      case (i % 4)
        0: p = 12'd1;
        1: p = 12'hFFF;
        2: p = 12'd3;
        default: p = 12'hFFD;
      endcase
      step(p, 12'd0, 12'd0, rk(), rk(), rk(), 2'd0, (i < 12) ? 16'd0 : rc(), "R6");
    end

    // R7: largest positive products wrap modulo 2^16
    for (int s = 1; s <= 3; s++)
      step(12'd0, 12'd0, 12'd0, 10'h200, 10'h200, 10'h200, 2'(s), 16'd0, "R7");
    for (int i = 0; i < 10; i++) step(12'h800, 12'h800, 12'h800, rk(), rk(), rk(), 2'd0, 16'd0, "R7");
    for (int i = 0; i < 6; i++) step(12'h800, 12'h800, 12'h800, rk(), rk(), rk(), 2'd0, 16'h7FFF, "R7");

    // R9: hold code with busy coefficient ports
    for (int i = 0; i < 40; i++) step(rpix(), rpix(), rpix(), rk(), rk(), rk(), 2'd0, rc(), "R9");

    // R8: writes on many cycles, interleaved with pixel traffic
    for (int i = 0; i < 200; i++)
      step(rpix(), rpix(), rpix(), rk(), rk(), rk(), 2'($urandom % 4), rc(), "R8");

    // R3: ramp columns expose any slip of the window or of the output stage
    for (int i = 0; i < 40; i++)
      step(12'(i * 37), 12'(-i * 11), 12'(i + 500), rk(), rk(), rk(),
           (i < 3) ? 2'(i + 1) : 2'd0, 16'(i * 16), "R3");

    // R5: extreme codes of every format
    for (int i = 0; i < 200; i++)
      step(xpix(), xpix(), xpix(), xk(), xk(), xk(), 2'($urandom % 4), rc(), "R5");

    // R2: general traffic, occasional coefficient updates
    for (int i = 0; i < 500; i++)
      step(rpix(), rpix(), rpix(), rk(), rk(), rk(),
           (($urandom % 8) == 0) ? 2'(1 + $urandom % 3) : 2'd0, rc(), "R2");

    summary();
    $finish;
  end
endmodule